// File: doc/BRIEF.md
# Five-Channel Output Compare Unit

This block watches a 16-bit free-running count that a separate timer supplies and raises an event for each of five channels when the count reaches that channel's 16-bit compare value. Each event sets one bit in a flag byte. Software clears a flag by writing a one to it. A mask byte picks which flags may drive a single combined interrupt request.

A match is found by the span of values the count covered since the previous cycle, not by plain equality. A count that skips values, such as a prescaled or sampled counter catching up, still hits a compare value that falls in the skipped span. This also holds when the span wraps from 0xFFFF to 0x0000. A software reload of the count is flagged on its own input. On a reload, only the new value is checked, so a jump backwards cannot fire every channel in the skipped range.

Compare values are loaded a byte at a time. The high byte is staged and the full 16-bit value takes effect on the low-byte write, so no channel ever matches against a half-written value. Writing a compare value or the mask makes every channel check its compare value against the current count in the next cycle.

Top module: `oc5_unit`

## Requirements
- R1: After reset every compare value reads 0xFFFF, the mask byte and the flag byte read 0x00, and irq_o is low.
- R2: Channel i (1..5) has its high byte at address 2(i-1) and its low byte at 2(i-1)+1. A high-byte write is only staged and leaves the readback unchanged. The low-byte write loads {staged high, written low} as the compare value.
- R3: When the count steps by one onto a channel's compare value, flag bit 8-i of that channel (channel 1 is bit 7, channel 5 is bit 3) reads set from the clock edge that ends that cycle.
- R4: Without a reload, a channel matches whenever its compare value lies in the span (previous count, current count] taken modulo 2^16. This includes a span that wraps past 0xFFFF.
- R5: While the count holds its value and no re-evaluation is pending, no flag becomes set.
- R6: A write to address 11 clears each flag bit 7:3 written as one and leaves every bit written as zero unchanged.
- R7: A match in the same cycle as a write-one-to-clear of its flag leaves that flag set.
- R8: The mask byte sits at address 10. Bits 7:3 are stored and bits 2:0 read zero. Flag bits 2:0 read zero. irq_o is high exactly when some flag bit and its mask bit are both set.
- R9: After a write to any compare low byte or to the mask, each channel whose compare value equals the count in the next cycle sets its flag.
- R10: In a cycle with count_load_i high, and in the first cycle after reset, a channel matches only if its compare value equals count_i. No span is checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| count_i | input | 16 | Free-running count from the timer |
| count_load_i | input | 1 | Count was reloaded by software this cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address (0..9 compare bytes, 10 mask, 11 flags) |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 4 | Read address, same map as writes |
| rd_data_o | output | 8 | Read data for rd_addr_i (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a span match that wraps past 0xFFFF while several channels share the end points of that span. The stimulus parks channels at 0x0005 and at the reset value 0xFFFF, then moves the count from 0xFFF0 to 0x0010 in one cycle without a reload, so three flags must rise on the same edge. A second awkward case is a reload that jumps backwards across a compare value, which must stay silent, followed by a reload landing on that value, which must fire. A long random phase then mixes single steps, small skips, reloads and register writes. A behavioural model checks rd_data_o and irq_o on every cycle of that phase.

// File: rtl/oc5_pkg.sv
package oc5_pkg;

   // How a channel evaluates its compare value in the current cycle
   typedef struct packed {
      logic span_en;   // check the span (previous, current]
      logic equal_en;  // check equality with the current count
   } oc5_eval_t;

   // Flag bit position used by channel k (0-based), filled from the MSB down
   function automatic int oc5_flag_pos(input int k, input int dw);
      return dw - 1 - k;
   endfunction

endpackage

// File: rtl/oc5_count_track.sv
module oc5_count_track
   import oc5_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [CW-1:0] count_i,
   input  logic          load_i,
   input  logic          reeval_i,
   output logic [CW-1:0] prev_o,
   output oc5_eval_t     ctl_o
);

   logic [CW-1:0] prev_q;
   logic          primed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q   <= '0;
         primed_q <= 1'b0;
      end else begin
         prev_q   <= count_i;
         primed_q <= 1'b1;
      end
   end

   assign prev_o         = prev_q;
   assign ctl_o.span_en  = primed_q && !load_i;
   assign ctl_o.equal_en = reeval_i || load_i || !primed_q;

endmodule

// File: rtl/oc5_channel.sv
module oc5_channel
   import oc5_pkg::*;
#(
   parameter int DW         = 8,
   parameter bit STAGE_HIGH = 1'b1,
   localparam int CW        = 2 * DW
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          wr_hi_i,
   input  logic          wr_lo_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [CW-1:0] count_i,
   input  logic [CW-1:0] prev_i,
   input  oc5_eval_t     ctl_i,
   output logic [CW-1:0] cmp_o,
   output logic          hit_o
);

   logic [CW-1:0] cmp_q;
   logic [CW-1:0] dist_cmp;
   logic [CW-1:0] dist_cur;

   generate
      if (STAGE_HIGH) begin : g_staged
         logic [DW-1:0] hold_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               hold_q <= '1;
               cmp_q  <= '1;
            end else begin
               if (wr_hi_i) hold_q <= wdata_i;
               if (wr_lo_i) cmp_q  <= {hold_q, wdata_i};
            end
         end
         // high-byte writes alone never change the compare value
         assert_cmp_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !wr_lo_i |=> $stable(cmp_q));
      end else begin : g_direct
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cmp_q <= '1;
            end else begin
               if (wr_hi_i) cmp_q[CW-1:DW] <= wdata_i;
               if (wr_lo_i) cmp_q[DW-1:0]  <= wdata_i;
            end
         end
      end
   endgenerate

   // distances measured forward from the previous sample, modulo 2^CW
   assign dist_cmp = cmp_q - prev_i;
   assign dist_cur = count_i - prev_i;

   always_comb begin
      hit_o = 1'b0;
      if (ctl_i.span_en && (dist_cmp != '0) && (dist_cmp <= dist_cur)) hit_o = 1'b1;
      if (ctl_i.equal_en && (cmp_q == count_i)) hit_o = 1'b1;
   end

   assign cmp_o = cmp_q;

   assert_no_spurious_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (count_i == prev_i && !ctl_i.equal_en) |-> !hit_o);

endmodule

// File: rtl/oc5_flags.sv
module oc5_flags
   import oc5_pkg::*;
#(
   parameter int NCH = 5,
   parameter int DW  = 8
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic [NCH-1:0] hit_i,
   input  logic           wr_mask_i,
   input  logic           wr_flag_i,
   input  logic [DW-1:0]  wdata_i,
   output logic [DW-1:0]  flag_o,
   output logic [DW-1:0]  mask_o,
   output logic           irq_o
);

   localparam logic [DW-1:0] USED = ~({DW{1'b1}} >> NCH);

   logic [DW-1:0] flag_q, mask_q, set_vec, clr_vec;

   always_comb begin
      set_vec = '0;
      for (int k = 0; k < NCH; k++) set_vec[oc5_flag_pos(k, DW)] = hit_i[k];
   end

   assign clr_vec = wr_flag_i ? (wdata_i & USED) : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= '0;
         mask_q <= '0;
      end else begin
         flag_q <= (flag_q & ~clr_vec) | set_vec;
         if (wr_mask_i) mask_q <= wdata_i & USED;
      end
   end

   assign flag_o = flag_q;
   assign mask_o = mask_q;
   assign irq_o  = |(flag_q & mask_q);

   generate
      for (genvar b = DW - NCH; b < DW; b++) begin : g_chk
         assert_w1c_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flag_q[b] && !(wr_flag_i && wdata_i[b])) |=> flag_q[b]);
         assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_vec[b] |=> flag_q[b]);
      end
   endgenerate

   assert_irq_needs_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (mask_q != '0 && flag_q != '0));

endmodule

// File: rtl/oc5_unit.sv
module oc5_unit
   import oc5_pkg::*;
#(
   parameter int NCH        = 5,
   parameter int DW         = 8,
   parameter bit STAGE_HIGH = 1'b1,
   localparam int CW        = 2 * DW,
   localparam int AW        = $clog2(2 * NCH + 2)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [CW-1:0] count_i,
   input  logic          count_load_i,
   input  logic          wr_en_i,
   input  logic [AW-1:0] wr_addr_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic [AW-1:0] rd_addr_i,
   output logic [DW-1:0] rd_data_o,
   output logic          irq_o
);

   localparam logic [AW-1:0] ADDR_MASK = AW'(2 * NCH);
   localparam logic [AW-1:0] ADDR_FLAG = AW'(2 * NCH + 1);

   generate
      if (NCH < 1 || NCH > DW) begin : g_bad_nch
         $error("oc5_unit: NCH must lie in 1..DW");
      end
   endgenerate

   logic [CW-1:0]  cmp_w [NCH];
   logic [NCH-1:0] hit_w;
   logic [CW-1:0]  prev_w;
   oc5_eval_t      ctl_w;
   logic [DW-1:0]  flag_w, mask_w;
   logic           lo_wr, mask_wr, flag_wr, reeval_q;

   assign lo_wr   = wr_en_i && (wr_addr_i < ADDR_MASK) && wr_addr_i[0];
   assign mask_wr = wr_en_i && (wr_addr_i == ADDR_MASK);
   assign flag_wr = wr_en_i && (wr_addr_i == ADDR_FLAG);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) reeval_q <= 1'b0;
      else         reeval_q <= lo_wr || mask_wr;
   end

   oc5_count_track #(.CW(CW)) u_track (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .count_i  (count_i),
      .load_i   (count_load_i),
      .reeval_i (reeval_q),
      .prev_o   (prev_w),
      .ctl_o    (ctl_w)
   );

   generate
      for (genvar k = 0; k < NCH; k++) begin : g_ch
         localparam logic [AW-1:0] A_HI = AW'(2 * k);
         localparam logic [AW-1:0] A_LO = AW'(2 * k + 1);

         oc5_channel #(.DW(DW), .STAGE_HIGH(STAGE_HIGH)) u_ch (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .wr_hi_i (wr_en_i && wr_addr_i == A_HI),
            .wr_lo_i (wr_en_i && wr_addr_i == A_LO),
            .wdata_i (wr_data_i),
            .count_i (count_i),
            .prev_i  (prev_w),
            .ctl_i   (ctl_w),
            .cmp_o   (cmp_w[k]),
            .hit_o   (hit_w[k])
         );

         assert_reeval_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (reeval_q && cmp_w[k] == count_i) |-> hit_w[k]);
         assert_load_equal_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (count_load_i && hit_w[k]) |-> (cmp_w[k] == count_i));
      end
   endgenerate

   oc5_flags #(.NCH(NCH), .DW(DW)) u_flags (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hit_i     (hit_w),
      .wr_mask_i (mask_wr),
      .wr_flag_i (flag_wr),
      .wdata_i   (wr_data_i),
      .flag_o    (flag_w),
      .mask_o    (mask_w),
      .irq_o     (irq_o)
   );

   always_comb begin
      rd_data_o = '0;
      for (int k = 0; k < NCH; k++) begin
         if (rd_addr_i == AW'(2 * k))     rd_data_o = cmp_w[k][CW-1:DW];
         if (rd_addr_i == AW'(2 * k + 1)) rd_data_o = cmp_w[k][DW-1:0];
      end
      if (rd_addr_i == ADDR_MASK) rd_data_o = mask_w;
      if (rd_addr_i == ADDR_FLAG) rd_data_o = flag_w;
   end

endmodule

// File: tb/tb_oc5_unit.sv
module tb_oc5_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] count = 16'h0000;
   logic        load = 1'b0;
   logic        wr = 1'b0;
   logic [3:0]  wa = 4'd0;
   logic [7:0]  wd = 8'h00;
   logic [3:0]  ra = 4'd11;
   logic [7:0]  rd;
   logic        irq;

   always #4 clk = ~clk;

   oc5_unit dut (
      .clk_i(clk), .rst_ni(rst_n), .count_i(count), .count_load_i(load),
      .wr_en_i(wr), .wr_addr_i(wa), .wr_data_i(wd),
      .rd_addr_i(ra), .rd_data_o(rd), .irq_o(irq)
   );

   // behavioural reference state
   logic [15:0] m_cmp [5];
   logic [7:0]  m_hold [5];
   logic [7:0]  m_flag, m_mask;
   logic [15:0] m_prev;
   bit          m_primed, m_reeval;

   int    errs = 0;
   int    checks = 0;
   string phase = "R1";

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] m_read(input logic [3:0] a);
      if (a < 4'd10) return a[0] ? m_cmp[a >> 1][7:0] : m_cmp[a >> 1][15:8];
      if (a == 4'd10) return m_mask;
      if (a == 4'd11) return m_flag;
      return 8'h00;
   endfunction

   task automatic model_reset();
      for (int k = 0; k < 5; k++) begin m_cmp[k] = 16'hFFFF; m_hold[k] = 8'hFF; end
      m_flag = 8'h00; m_mask = 8'h00; m_prev = 16'h0000;
      m_primed = 1'b0; m_reeval = 1'b0;
   endtask

   // one clock: predict from current inputs, wait, commit, compare
   task automatic cyc();
      logic [7:0]  nf;
      logic [15:0] dc, du;
      logic [15:0] ncmp [5];
      logic [7:0]  nhold [5];
      logic [7:0]  nmask;
      bit          hit, nre;
      nf = m_flag;
      if (wr && wa == 4'd11) nf = nf & ~(wd & 8'hF8);
      du = count - m_prev;
      for (int k = 0; k < 5; k++) begin
         dc  = m_cmp[k] - m_prev;
         hit = (m_primed && !load && dc != 16'h0 && dc <= du) ||
               ((m_reeval || load || !m_primed) && m_cmp[k] == count);
         if (hit) nf[7-k] = 1'b1;
         ncmp[k] = m_cmp[k]; nhold[k] = m_hold[k];
         if (wr && wa == 4'(2*k))   nhold[k] = wd;
         if (wr && wa == 4'(2*k+1)) ncmp[k]  = {m_hold[k], wd};
      end
      nmask = m_mask;
      if (wr && wa == 4'd10) nmask = wd & 8'hF8;
      nre = wr && ((wa < 4'd10 && wa[0]) || wa == 4'd10);
      @(posedge clk);
      @(negedge clk);
      for (int k = 0; k < 5; k++) begin m_cmp[k] = ncmp[k]; m_hold[k] = nhold[k]; end
      m_flag = nf; m_mask = nmask; m_prev = count; m_primed = 1'b1; m_reeval = nre;
      chk({phase, " rd_data"}, rd, m_read(ra));
      chk({phase, " irq"}, irq, |(m_flag & m_mask));
   endtask

   task automatic wrb(input logic [3:0] a, input logic [7:0] d);
      wr = 1'b1; wa = a; wd = d;
      cyc();
      wr = 1'b0;
   endtask

   task automatic setc(input int k, input logic [15:0] v);
      wrb(4'(2*k), v[15:8]);
      wrb(4'(2*k+1), v[7:0]);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      phase = "R1";
      for (int a = 0; a < 12; a++) begin
         ra = 4'(a);
         cyc();
         chk("R1 reset readback", rd, (a < 10) ? 8'hFF : 8'h00);
      end
      chk("R1 irq low", irq, 0);

      // R2: staged high byte
      phase = "R2";
      ra = 4'd0;
      wrb(4'd0, 8'h12);
      chk("R2 high staged only", rd, 8'hFF);
      wrb(4'd1, 8'h34);
      chk("R2 high after low write", rd, 8'h12);
      ra = 4'd1; cyc();
      chk("R2 low after low write", rd, 8'h34);

      // R3: single steps onto 0x1234
      phase = "R3";
      ra = 4'd11;
      for (int v = 16'h1230; v <= 16'h1233; v++) begin count = 16'(v); cyc(); end
      chk("R3 no flag before match", rd, 8'h00);
      count = 16'h1234; cyc();
      chk("R3 channel 1 bit 7", rd, 8'h80);
      count = 16'h1235; cyc();
      wrb(4'd11, 8'h80);
      chk("R6 clear by one", rd, 8'h00);

      // R4: forward jump and wrap
      phase = "R4";
      setc(1, 16'h2000);
      count = 16'h1F00; cyc();
      chk("R4 short of compare", rd, 8'h00);
      count = 16'h2100; cyc();
      chk("R4 jump across 0x2000", rd, 8'h40);
      wrb(4'd11, 8'h40);
      setc(2, 16'h0005);
      count = 16'hFFF0; cyc();
      chk("R4 before wrap", rd, 8'h00);
      count = 16'h0010; cyc();
      chk("R4 wrap hits 0x0005 and 0xFFFF", rd, 8'h38);
      wrb(4'd11, 8'h38);

      // R9: compare write onto the held count
      phase = "R9";
      setc(3, 16'h0010);
      cyc();
      chk("R9 re-evaluation after compare write", rd, 8'h10);

      // R5: held count makes no new match
      phase = "R5";
      wrb(4'd11, 8'h10);
      repeat (5) cyc();
      chk("R5 stationary count", rd, 8'h00);

      // R6 / R8
      phase = "R6";
      wrb(4'd10, 8'hFF);
      cyc();
      chk("R9 re-evaluation after mask write", rd, 8'h10);
      wrb(4'd11, 8'h00);
      chk("R6 zero write keeps flag", rd, 8'h10);
      wrb(4'd11, 8'hEF);
      chk("R6 other ones keep flag", rd, 8'h10);
      phase = "R8";
      ra = 4'd10; cyc();
      chk("R8 mask readback", rd, 8'hF8);
      chk("R8 irq with enabled flag", irq, 1);
      wrb(4'd10, 8'hE8);
      chk("R8 irq with flag masked", irq, 0);
      ra = 4'd11; cyc();

      // R7: set wins over clear
      phase = "R7";
      setc(4, 16'h0011);
      wr = 1'b1; wa = 4'd11; wd = 8'h08; count = 16'h0011;
      cyc();
      wr = 1'b0;
      chk("R7 set wins", rd & 8'h08, 8'h08);

      // R10: reloads check equality only
      phase = "R10";
      wrb(4'd11, 8'hF8);
      load = 1'b1; count = 16'h3000; cyc();
      count = 16'h1000; cyc();
      load = 1'b0;
      chk("R10 backward reload silent", rd, 8'h00);
      load = 1'b1; count = 16'h2000; cyc();
      load = 1'b0;
      chk("R10 reload onto compare", rd, 8'h40);

      // random mix, compared every cycle
      phase = "R3/R4/R9/R10 random";
      for (int n = 0; n < 4000; n++) begin
         int unsigned r;
         r = $urandom_range(0, 99);
         load = 1'b0;
         if (r < 70)      count = count + 16'd1;
         else if (r < 80) count = count + 16'($urandom_range(2, 300));
         else if (r < 84) begin load = 1'b1; count = 16'($urandom); end
         wr = ($urandom_range(0, 9) == 0);
         wa = 4'($urandom_range(0, 11));
         wd = 8'($urandom);
         ra = 4'($urandom_range(0, 11));
         cyc();
      end
      wr = 1'b0; load = 1'b0;
      finish_run();
   end

endmodule